// File: doc/BRIEF.md
# Bus Transfer Error Terminator

This block decides how each processor bus cycle ends: with a normal acknowledge or with a transfer-error acknowledge. When a cycle starts, it looks at the transfer size, the low address bits and the cycle's attributes. Cycles that the bus cannot carry end at once. Examples are a misaligned access, a transfer size that is never legal, a programmed-I/O cycle, or a burst or wide transfer aimed at PCI.

Legal cycles wait for their target. A memory cycle ends when the memory side signals completion. If that completion carries a parity error, the cycle ends with the error acknowledge. A PCI cycle waits for FRAME, then for DEVSEL inside a fixed window, then for completion or a target abort inside a timeout. One counter serves both the DEVSEL window and the response timeout.

A mask input turns the error acknowledge into a normal acknowledge, except on programmed-I/O cycles. Each transfer-type error also raises a one-clock pulse for the error-address capture unit. Out-of-range memory cycles end normally. On reads the data path is told to return all ones. On writes it is told to discard the data.

Top module: `bus_err_term`

## Requirements
- R1: Outside bursts, `xferSize` gives the byte count in binary (1 to 8), and `addrLow` gives address bits [2:0]. The legal combinations are: 1 byte at any alignment; 2 bytes except at 7; 3 bytes at 0 to 5; 4 bytes at 0 to 4; 8 bytes only at 0. Sizes 0, 5, 6 and 7 are never legal. An illegal combination terminates the cycle in the clock after `cycStart` with `errAck` and a `ttErr` pulse.
- R2: A cycle with `tgtPci` high that is a burst, or that moves 5 or more bytes, terminates in the clock after `cycStart` with `errAck` and `ttErr`.
- R3: A cycle with `isPio` high terminates in the clock after `cycStart` with `errAck` and `ttErr`, whatever the value of `maskErr`.
- R4: A legal memory cycle ends in the clock after the edge that samples `memDone`. It ends with `errAck` if `memParErr` is high at that edge and with `normAck` otherwise. In neither case does `ttErr` pulse.
- R5: On a PCI cycle, DEVSEL is accepted on any of the first WIN_CLKS edges after the edge that samples `pciFrame`. If DEVSEL does not arrive in that window, a normal cycle ends with `errAck` and `ttErr`. A configuration cycle instead ends with `normAck`, plus `fillOnes` if it was a read.
- R6: After DEVSEL, `pciAbort` ends the cycle with `errAck` and `ttErr`, and `pciDone` ends it with `normAck`. If both are present at the same edge, the abort wins.
- R7: If neither `pciAbort` nor `pciDone` arrives on the first TO_CLKS edges after the DEVSEL edge, the cycle ends with `errAck` and `ttErr`.
- R8: When `maskErr` is high at the deciding edge, every error termination other than a programmed-I/O one appears as `normAck`. The `ttErr` pulse is unchanged.
- R9: A memory cycle with `outOfRange` high ends with `normAck` in the clock after `cycStart`. It also raises `fillOnes` for a read and `dropWrite` for a write.
- R10: Each cycle gets exactly one acknowledge (`errAck` or `normAck`), lasting one clock. A `cycStart` that arrives while a cycle is open, or during its acknowledge clock, is ignored.
- R11: While `rstN` is low, all five outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cycStart | input | 1 | Start-of-cycle strobe; attributes are valid with it |
| xferSize | input | SIZE_W | Byte count of a single-beat transfer |
| addrLow | input | ADDR_LO_W | Low address bits of the transfer |
| isBurst | input | 1 | Cycle is a burst |
| tgtPci | input | 1 | Target is PCI; otherwise system memory |
| isPio | input | 1 | Programmed-I/O cycle |
| isCfg | input | 1 | PCI configuration cycle |
| isRead | input | 1 | Cycle is a read |
| outOfRange | input | 1 | Memory address lies beyond installed memory |
| memDone | input | 1 | Memory side completed the access |
| memParErr | input | 1 | Parity error, valid with memDone |
| pciFrame | input | 1 | PCI FRAME has been driven for this cycle |
| pciDevsel | input | 1 | PCI DEVSEL seen |
| pciAbort | input | 1 | PCI target abort seen |
| pciDone | input | 1 | PCI target completed the data phase |
| maskErr | input | 1 | Turn error acknowledges into normal ones |
| errAck | output | 1 | Transfer-error acknowledge, one clock |
| normAck | output | 1 | Normal acknowledge, one clock |
| ttErr | output | 1 | Transfer-type-error pulse to the capture unit |
| fillOnes | output | 1 | Read data must be all ones; with normAck |
| dropWrite | output | 1 | Write data must be discarded; with normAck |

## Verification
The bench builds the block with a DEVSEL window of 7 clocks and a response timeout of 24 clocks instead of 1980. With the shorter timeout, the expiry and the exact last-accepted edge of both timers can be reached in a few dozen clocks each. That makes it practical to place DEVSEL and completion exactly on and one past each limit. All 64 size and alignment combinations are swept to memory. The mask is toggled against programmed-I/O, parity, size and no-DEVSEL errors.

// File: rtl/bus_err_term_pkg.sv
package bus_err_term_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch cycle attributes
    logic cntClr;   // restart the shared timer
    logic cntInc;   // advance the shared timer
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEMWAIT,
    ST_FRAMEWAIT,
    ST_DEVWAIT,
    ST_RESPWAIT,
    ST_ACK
  } termState_t;

endpackage

// File: rtl/bus_err_term_dp.sv
module bus_err_term_dp
  import bus_err_term_pkg::*;
#(
  parameter int SIZE_W    = 4,
  parameter int ADDR_LO_W = 3,
  parameter int WIN_CLKS  = 7,
  parameter int TO_CLKS   = 1980
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [SIZE_W-1:0]    xferSize,
  input  logic [ADDR_LO_W-1:0] addrLow,
  input  logic                 isBurst,
  input  logic                 tgtPci,
  input  logic                 isPio,
  input  logic                 isCfg,
  input  logic                 isRead,
  output logic                 typeErr,
  output logic                 pioNow,
  output logic                 latCfg,
  output logic                 latRead,
  output logic                 winExpired,
  output logic                 toExpired
);

  localparam int SPAN    = 1 << ADDR_LO_W;
  localparam int HALF    = SPAN / 2;
  localparam int SUM_W   = ((SIZE_W > ADDR_LO_W) ? SIZE_W : ADDR_LO_W) + 1;
  localparam int CNT_MAX = (WIN_CLKS > TO_CLKS) ? WIN_CLKS : TO_CLKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [SUM_W-1:0] endByte;
  logic             sizeBad;
  logic             pciBad;
  logic [CNT_W-1:0] cnt;

  // a single transfer may not run past the end of the doubleword
  always_comb begin
    endByte = SUM_W'(xferSize) + SUM_W'(addrLow);
    sizeBad = (xferSize == '0)
            || ((xferSize > SIZE_W'(HALF)) && (xferSize != SIZE_W'(SPAN)))
            || (endByte > SUM_W'(SPAN));
    pciBad  = tgtPci && (isBurst || (xferSize > SIZE_W'(HALF)));
    typeErr = isPio || (!isBurst && sizeBad) || pciBad;
    pioNow  = isPio;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latCfg  <= 1'b0;
      latRead <= 1'b0;
    end else if (strobe.capture) begin
      latCfg  <= isCfg;
      latRead <= isRead;
    end
  end

  // one counter serves the DEVSEL window and the response timeout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntInc) cnt <= cnt + 1'b1;
  end

  assign winExpired = (cnt == CNT_W'(WIN_CLKS - 1));
  assign toExpired  = (cnt == CNT_W'(TO_CLKS - 1));

endmodule

// File: rtl/bus_err_term_ctrl.sv
module bus_err_term_ctrl
  import bus_err_term_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cycStart,
  input  logic      tgtPci,
  input  logic      isRead,
  input  logic      outOfRange,
  input  logic      memDone,
  input  logic      memParErr,
  input  logic      pciFrame,
  input  logic      pciDevsel,
  input  logic      pciAbort,
  input  logic      pciDone,
  input  logic      maskErr,
  input  logic      typeErr,
  input  logic      pioNow,
  input  logic      latCfg,
  input  logic      latRead,
  input  logic      winExpired,
  input  logic      toExpired,
  output dpStrobe_t strobe,
  output logic      errAck,
  output logic      normAck,
  output logic      ttErr,
  output logic      fillOnes,
  output logic      dropWrite
);

  termState_t st, nxt;
  logic doTerm, tErr, tTt, tOnes, tDrop, tPio, useErr;

  always_comb begin
    nxt    = st;
    strobe = '0;
    doTerm = 1'b0;
    tErr   = 1'b0;
    tTt    = 1'b0;
    tOnes  = 1'b0;
    tDrop  = 1'b0;
    tPio   = 1'b0;
    case (st)
      ST_IDLE: if (cycStart) begin
        strobe.capture = 1'b1;
        strobe.cntClr  = 1'b1;
        if (typeErr) begin
          doTerm = 1'b1; tErr = 1'b1; tTt = 1'b1; tPio = pioNow;
        end else if (tgtPci) begin
          nxt = ST_FRAMEWAIT;
        end else if (outOfRange) begin
          doTerm = 1'b1; tOnes = isRead; tDrop = !isRead;
        end else begin
          nxt = ST_MEMWAIT;
        end
      end
      ST_MEMWAIT: if (memDone) begin
        doTerm = 1'b1; tErr = memParErr;
      end
      ST_FRAMEWAIT: if (pciFrame) begin
        nxt = ST_DEVWAIT; strobe.cntClr = 1'b1;
      end
      ST_DEVWAIT: begin
        if (pciDevsel) begin
          nxt = ST_RESPWAIT; strobe.cntClr = 1'b1;
        end else if (winExpired) begin
          doTerm = 1'b1;
          if (latCfg) tOnes = latRead;
          else begin tErr = 1'b1; tTt = 1'b1; end
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_RESPWAIT: begin
        if (pciAbort || (!pciDone && toExpired)) begin
          doTerm = 1'b1; tErr = 1'b1; tTt = 1'b1;
        end else if (pciDone) begin
          doTerm = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_ACK:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    if (doTerm) nxt = ST_ACK;
    useErr = tErr && (!maskErr || tPio);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      errAck    <= 1'b0;
      normAck   <= 1'b0;
      ttErr     <= 1'b0;
      fillOnes  <= 1'b0;
      dropWrite <= 1'b0;
    end else begin
      st        <= nxt;
      errAck    <= doTerm && useErr;
      normAck   <= doTerm && !useErr;
      ttErr     <= doTerm && tTt;
      fillOnes  <= doTerm && tOnes;
      dropWrite <= doTerm && tDrop;
    end
  end

endmodule

// File: rtl/bus_err_term.sv
module bus_err_term
  import bus_err_term_pkg::*;
#(
  parameter int SIZE_W    = 4,
  parameter int ADDR_LO_W = 3,
  parameter int WIN_CLKS  = 7,
  parameter int TO_CLKS   = 1980
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cycStart,
  input  logic [SIZE_W-1:0]    xferSize,
  input  logic [ADDR_LO_W-1:0] addrLow,
  input  logic                 isBurst,
  input  logic                 tgtPci,
  input  logic                 isPio,
  input  logic                 isCfg,
  input  logic                 isRead,
  input  logic                 outOfRange,
  input  logic                 memDone,
  input  logic                 memParErr,
  input  logic                 pciFrame,
  input  logic                 pciDevsel,
  input  logic                 pciAbort,
  input  logic                 pciDone,
  input  logic                 maskErr,
  output logic                 errAck,
  output logic                 normAck,
  output logic                 ttErr,
  output logic                 fillOnes,
  output logic                 dropWrite
);

  dpStrobe_t strobe;
  logic typeErr, pioNow, latCfg, latRead, winExpired, toExpired;

  bus_err_term_dp #(
    .SIZE_W(SIZE_W), .ADDR_LO_W(ADDR_LO_W),
    .WIN_CLKS(WIN_CLKS), .TO_CLKS(TO_CLKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .xferSize(xferSize), .addrLow(addrLow), .isBurst(isBurst),
    .tgtPci(tgtPci), .isPio(isPio), .isCfg(isCfg), .isRead(isRead),
    .typeErr(typeErr), .pioNow(pioNow), .latCfg(latCfg), .latRead(latRead),
    .winExpired(winExpired), .toExpired(toExpired)
  );

  bus_err_term_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cycStart(cycStart), .tgtPci(tgtPci),
    .isRead(isRead), .outOfRange(outOfRange), .memDone(memDone),
    .memParErr(memParErr), .pciFrame(pciFrame), .pciDevsel(pciDevsel),
    .pciAbort(pciAbort), .pciDone(pciDone), .maskErr(maskErr),
    .typeErr(typeErr), .pioNow(pioNow), .latCfg(latCfg), .latRead(latRead),
    .winExpired(winExpired), .toExpired(toExpired), .strobe(strobe),
    .errAck(errAck), .normAck(normAck), .ttErr(ttErr),
    .fillOnes(fillOnes), .dropWrite(dropWrite)
  );

endmodule

// File: rtl/bus_err_term_chk.sv
module bus_err_term_chk (
  input logic clk,
  input logic rstN,
  input logic maskErr,
  input logic errAck,
  input logic normAck,
  input logic ttErr,
  input logic fillOnes,
  input logic dropWrite
);

  // R10: never both acknowledges together
  p_ack_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(errAck && normAck));

  // R10: an acknowledge lasts one clock
  p_ack_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    (errAck || normAck) |=> !(errAck || normAck));

  // R8: the type-error pulse always rides on an acknowledge
  p_tt_with_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    ttErr |-> (errAck || normAck));

  // R8: a type error acknowledged normally needs the mask at the deciding edge
  p_mask_swap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (normAck && ttErr) |-> $past(maskErr));

  // R9: data qualifiers only with a normal acknowledge, never both
  p_qual_normal_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fillOnes || dropWrite) |-> (normAck && !(fillOnes && dropWrite)));

endmodule

bind bus_err_term bus_err_term_chk u_chk (
  .clk(clk), .rstN(rstN), .maskErr(maskErr), .errAck(errAck),
  .normAck(normAck), .ttErr(ttErr), .fillOnes(fillOnes), .dropWrite(dropWrite)
);

// File: tb/bus_err_term_tb.sv
`timescale 1ns/1ps
module bus_err_term_tb;

  localparam int WIN = 7;
  localparam int TO  = 24;

  logic clk = 1'b0, rstN = 1'b0;
  logic cycStart = 0, isBurst = 0, tgtPci = 0, isPio = 0, isCfg = 0, isRead = 0;
  logic outOfRange = 0, memDone = 0, memParErr = 0;
  logic pciFrame = 0, pciDevsel = 0, pciAbort = 0, pciDone = 0, maskErr = 0;
  logic [3:0] xferSize = 4'd1;
  logic [2:0] addrLow = 3'd0;
  logic errAck, normAck, ttErr, fillOnes, dropWrite;

  int checks = 0, fails = 0;
  bit finished = 0;
  string curReq = "R11 reset";

  always #5 clk = ~clk;

  bus_err_term #(.WIN_CLKS(WIN), .TO_CLKS(TO)) u_dut (
    .clk(clk), .rstN(rstN), .cycStart(cycStart), .xferSize(xferSize),
    .addrLow(addrLow), .isBurst(isBurst), .tgtPci(tgtPci), .isPio(isPio),
    .isCfg(isCfg), .isRead(isRead), .outOfRange(outOfRange),
    .memDone(memDone), .memParErr(memParErr), .pciFrame(pciFrame),
    .pciDevsel(pciDevsel), .pciAbort(pciAbort), .pciDone(pciDone),
    .maskErr(maskErr), .errAck(errAck), .normAck(normAck), .ttErr(ttErr),
    .fillOnes(fillOnes), .dropWrite(dropWrite)
  );

  // legality table written out per size
  function automatic bit legalSize(int sz, int a);
    case (sz)
      1: return 1;
      2: return a != 7;
      3: return a <= 5;
      4: return a <= 4;
      8: return a == 0;
      default: return 0;
    endcase
  endfunction

  // behavioural reference: phase 0 idle, 1 memory, 2 frame, 3 devsel, 4 response, 5 ack
  int ph = 0, k = 0;
  bit cfgL = 0, rdL = 0;
  bit [4:0] expV = '0;  // {errAck, normAck, ttErr, fillOnes, dropWrite}

  always @(posedge clk) begin
    bit fire, e, t, o, d, p;
    fire = 0; e = 0; t = 0; o = 0; d = 0; p = 0;
    if (!rstN) begin
      ph = 0; k = 0; expV = '0;
    end else begin
      if (ph == 5) ph = 0;
      else if (ph == 0) begin
        if (cycStart) begin
          cfgL = isCfg; rdL = isRead;
          if (isPio || (!isBurst && !legalSize(int'(xferSize), int'(addrLow)))
              || (tgtPci && (isBurst || xferSize >= 5))) begin
            fire = 1; e = 1; t = 1; p = isPio;
          end else if (tgtPci) ph = 2;
          else if (outOfRange) begin fire = 1; o = isRead; d = !isRead; end
          else ph = 1;
        end
      end else if (ph == 1) begin
        if (memDone) begin fire = 1; e = memParErr; end
      end else if (ph == 2) begin
        if (pciFrame) begin ph = 3; k = 0; end
      end else if (ph == 3) begin
        k++;
        if (pciDevsel) begin ph = 4; k = 0; end
        else if (k == WIN) begin
          fire = 1;
          if (cfgL) o = rdL; else begin e = 1; t = 1; end
        end
      end else if (ph == 4) begin
        k++;
        if (pciAbort) begin fire = 1; e = 1; t = 1; end
        else if (pciDone) fire = 1;
        else if (k == TO) begin fire = 1; e = 1; t = 1; end
      end
      if (fire) begin
        bit useE;
        useE = e && (!maskErr || p);
        ph = 5;
        expV = {useE, !useE, t, o, d};
      end else expV = '0;
    end
  end

  always @(negedge clk) begin
    bit [4:0] got;
    got = {errAck, normAck, ttErr, fillOnes, dropWrite};
    checks++;
    if (got !== expV) begin
      fails++;
      $display("FAIL %s: {err,norm,tt,ones,drop} got %b expected %b at %0t",
               curReq, got, expV, $time);
    end
  end

  task automatic startCyc(int sz, int a, bit burst, bit pci, bit pio, bit cfg,
                          bit rd, bit oor);
    @(negedge clk);
    xferSize = 4'(sz); addrLow = 3'(a); isBurst = burst; tgtPci = pci;
    isPio = pio; isCfg = cfg; isRead = rd; outOfRange = oor; cycStart = 1;
    @(negedge clk);
    cycStart = 0;
  endtask

  task automatic memResp(int dly, bit par);
    repeat (dly) @(negedge clk);
    memDone = 1; memParErr = par;
    @(negedge clk);
    memDone = 0; memParErr = 0;
    repeat (3) @(negedge clk);
  endtask

  // kind: 0 done, 1 abort, 2 nothing; devDly < 0 means no DEVSEL
  task automatic pciResp(int frDly, int devDly, int kind, int rspDly);
    repeat (frDly) @(negedge clk);
    pciFrame = 1; @(negedge clk); pciFrame = 0;
    if (devDly >= 0) begin
      repeat (devDly - 1) @(negedge clk);
      pciDevsel = 1; @(negedge clk); pciDevsel = 0;
      if (kind != 2) begin
        repeat (rspDly - 1) @(negedge clk);
        if (kind == 1) pciAbort = 1; else pciDone = 1;
        @(negedge clk);
        pciAbort = 0; pciDone = 0;
      end
    end
    repeat (TO + WIN + 4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);

    curReq = "R1 size/alignment sweep";
    for (int sz = 1; sz <= 8; sz++)
      for (int a = 0; a < 8; a++) begin
        startCyc(sz, a, 0, 0, 0, 0, 1, 0);
        memResp(2, 0);
      end
    curReq = "R1 size zero";
    startCyc(0, 0, 0, 0, 0, 0, 0, 0); memResp(1, 0);

    curReq = "R2 PCI burst";
    startCyc(8, 0, 1, 1, 0, 0, 1, 0); pciResp(1, 1, 0, 1);
    curReq = "R2 PCI eight bytes";
    startCyc(8, 0, 0, 1, 0, 0, 0, 0); pciResp(1, 1, 0, 1);
    curReq = "R1 memory burst legal";
    startCyc(8, 0, 1, 0, 0, 0, 1, 0); memResp(3, 0);

    curReq = "R3 PIO unmasked";
    startCyc(4, 0, 0, 0, 1, 0, 1, 0); memResp(1, 0);
    curReq = "R3 PIO masked";
    maskErr = 1;
    startCyc(4, 0, 0, 0, 1, 0, 1, 0); memResp(1, 0);
    maskErr = 0;

    curReq = "R4 memory parity";
    startCyc(4, 4, 0, 0, 0, 0, 1, 0); memResp(3, 1);
    curReq = "R4 memory clean";
    startCyc(2, 2, 0, 0, 0, 0, 0, 0); memResp(5, 0);

    curReq = "R5 DEVSEL on last window edge";
    startCyc(4, 0, 0, 1, 0, 0, 1, 0); pciResp(2, WIN, 0, 2);
    curReq = "R5 DEVSEL one past window";
    startCyc(4, 0, 0, 1, 0, 0, 1, 0); pciResp(2, WIN + 1, 0, 2);
    curReq = "R5 no DEVSEL";
    startCyc(1, 3, 0, 1, 0, 0, 0, 0); pciResp(0, -1, 2, 0);
    curReq = "R5 config read no DEVSEL";
    startCyc(4, 0, 0, 1, 0, 1, 1, 0); pciResp(1, -1, 2, 0);
    curReq = "R5 config write no DEVSEL";
    startCyc(4, 0, 0, 1, 0, 1, 0, 0); pciResp(1, -1, 2, 0);

    curReq = "R6 target abort";
    startCyc(4, 0, 0, 1, 0, 0, 1, 0); pciResp(1, 2, 1, 3);
    curReq = "R6 target done";
    startCyc(2, 6, 0, 1, 0, 0, 0, 0); pciResp(1, 1, 0, 1);

    curReq = "R7 done on last timeout edge";
    startCyc(4, 0, 0, 1, 0, 0, 1, 0); pciResp(1, 1, 0, TO);
    curReq = "R7 timeout";
    startCyc(4, 0, 0, 1, 0, 0, 1, 0); pciResp(1, 1, 2, 0);

    curReq = "R8 mask parity";
    maskErr = 1;
    startCyc(4, 0, 0, 0, 0, 0, 1, 0); memResp(2, 1);
    curReq = "R8 mask size error";
    startCyc(3, 7, 0, 0, 0, 0, 1, 0); memResp(1, 0);
    curReq = "R8 mask no DEVSEL";
    startCyc(4, 0, 0, 1, 0, 0, 1, 0); pciResp(1, -1, 2, 0);
    curReq = "R8 mask abort";
    startCyc(4, 0, 0, 1, 0, 0, 1, 0); pciResp(1, 1, 1, 1);
    maskErr = 0;

    curReq = "R9 out-of-range read";
    startCyc(8, 0, 0, 0, 0, 0, 1, 1); memResp(1, 0);
    curReq = "R9 out-of-range write";
    startCyc(4, 4, 0, 0, 0, 0, 0, 1); memResp(1, 0);

    curReq = "R10 start while busy";
    startCyc(4, 0, 0, 0, 0, 0, 1, 0);
    startCyc(3, 7, 0, 0, 0, 0, 1, 0);
    startCyc(4, 0, 0, 0, 1, 0, 1, 0);
    memResp(1, 0);
    curReq = "R10 start during ack";
    startCyc(3, 7, 0, 0, 0, 0, 1, 0);
    startCyc(2, 7, 0, 0, 0, 0, 1, 0);
    repeat (4) @(negedge clk);

    curReq = "R11 reset mid-cycle";
    startCyc(4, 0, 0, 0, 0, 0, 1, 0);
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    memResp(1, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule